// File: doc/BRIEF.md
# Banked Operand Memory for Parallel Modular Multipliers

This block holds the field-element operands of a prime-field elliptic-curve datapath built around `NBANK` modular multipliers. Storage is split into `NBANK` dual-port RAM banks. The first port of each bank is wired straight to one multiplier, with no operand registers between them. A multiplier can therefore stream its own operands every cycle, but it cannot see any other bank.

The second port of every bank is time-shared. While the `busy` flag is low, a protocol-side host reaches any bank through one flat address. The upper address bits pick the bank and the lower bits pick the word. While `busy` is high, the second ports belong to the shared modular-arithmetic unit, which drives all of them at once. A built-in copy engine moves a run of words from one bank to another, so that a value produced next to one multiplier can reach a different multiplier. During a copy the engine takes the second port of only the two banks involved.

The multipliers, the arithmetic unit and the curve sequencer are outside this block and appear only as port-level traffic.

Top module: `opmem_banked`

## Requirements
- R1: A read on a multiplier port (`mul_en` high, `mul_we` low) returns the word at `mul_addr` of that multiplier's own bank on `mul_rdata` one clock cycle later.
- R2: A write on multiplier port i changes only bank i. The same word address in every other bank keeps its contents.
- R3: When the multiplier port and the second port write the same address of one bank in the same cycle, the multiplier's value is stored. Writes from the two ports to different addresses both take effect.
- R4: While `busy` is low, a host access uses `host_addr[AW+BW-1:AW]` as the bank index and `host_addr[AW-1:0]` as the word. A host read returns the data on `host_rdata`, with `host_rvalid` high, exactly one cycle later. `host_rvalid` is high only in that cycle.
- R5: A host access attempted while `busy` is high, or with a bank index of `NBANK` or more, is dropped: no bank changes and `host_rvalid` stays low. Such an access sets `host_err`, which stays set until reset.
- R6: `busy` loads `busy_req` at each clock edge, with two exceptions. It keeps its value at an edge where a host access is accepted. It stays high during a copy and at the edge that ends the copy.
- R7: While `busy` is high and no copy is running, the arithmetic-unit port of every bank serves reads and writes in the same cycle. Reads return data one cycle later on `alu_rdata`.
- R8: A copy command (`copy_start`) is accepted only when all of these hold: `busy` is high, no copy is running, `copy_cnt` is not zero, `copy_src` differs from `copy_dst`, and both are below `NBANK`. It then copies `copy_cnt` words, source word (`copy_off`+k) to destination word (`copy_off`+k), with the offset wrapping modulo the bank depth.
- R9: `copy_busy` is high for `copy_cnt`+1 cycles, starting in the cycle after the accepting edge. `copy_done` is then high for exactly one cycle, the cycle in which `copy_busy` falls.
- R10: During a copy, the arithmetic unit keeps full use of every bank other than the source and destination banks. Its requests to the source and destination banks are ignored.
- R11: A copy command that fails any acceptance condition of R8 leaves `copy_busy` and `copy_done` low and changes no bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mul_en | input | NBANK | Per-multiplier port enable |
| mul_we | input | NBANK | Per-multiplier write enable |
| mul_addr | input | NBANK*AW | Per-multiplier word address, bank i in slice i |
| mul_wdata | input | NBANK*DW | Per-multiplier write data |
| mul_rdata | output | NBANK*DW | Per-multiplier read data |
| busy_req | input | 1 | Request to hand the second ports to the arithmetic unit |
| busy | output | 1 | Registered ownership flag of the second ports |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | Host write enable |
| host_addr | input | BW+AW | Host flat address {bank, word} |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Host read data |
| host_rvalid | output | 1 | Host read data valid |
| host_err | output | 1 | Sticky dropped-access flag |
| alu_en | input | NBANK | Arithmetic-unit enable per bank |
| alu_we | input | NBANK | Arithmetic-unit write enable per bank |
| alu_addr | input | NBANK*AW | Arithmetic-unit word address per bank |
| alu_wdata | input | NBANK*DW | Arithmetic-unit write data per bank |
| alu_rdata | output | NBANK*DW | Second-port read data per bank |
| copy_start | input | 1 | Copy command strobe |
| copy_src | input | BW | Copy source bank |
| copy_dst | input | BW | Copy destination bank |
| copy_off | input | AW | First word offset, used in both banks |
| copy_cnt | input | AW+1 | Number of words to move |
| copy_busy | output | 1 | Copy in progress |
| copy_done | output | 1 | One-cycle copy completion pulse |

## Verification
The memory image is swept near-exhaustively through each of the three access paths: host, multiplier ports and arithmetic-unit ports. Every bank gets a distinct arithmetic pattern, so any mix-up of bank index and word offset shows up as a wrong value. Single-bank multiplier writes separate a private port from one that leaks into other banks. Same-address and different-address dual writes separate the priority rule from plain port independence. Copies are tried with a mid-bank run, a run that wraps past the top word, and a whole-bank run, each also checked for timing. Side traffic during a copy, and a set of malformed commands, tell ignored requests apart from ones that are carried out.

// File: rtl/opmem_pkg.sv
package opmem_pkg;

   // width of an index over n items, never below one bit
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // who drives a bank's second port in the current cycle
   typedef enum logic [1:0] {
      PB_HOST = 2'd0,
      PB_ALU  = 2'd1,
      PB_CPRD = 2'd2,
      PB_CPWR = 2'd3
   } pb_owner_e;

endpackage

// File: rtl/opmem_bank.sv
module opmem_bank #(
   parameter int DW     = 16,
   parameter int AW     = 4,
   parameter bit A_WINS = 1'b1,
   localparam int DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          a_en,
   input  logic          a_we,
   input  logic [AW-1:0] a_addr,
   input  logic [DW-1:0] a_wd,
   output logic [DW-1:0] a_rd,
   input  logic          b_en,
   input  logic          b_we,
   input  logic [AW-1:0] b_addr,
   input  logic [DW-1:0] b_wd,
   output logic [DW-1:0] b_rd
);

   logic [DW-1:0] mem [DEPTH];

   // write order picks the winner of a same-address collision (R3)
   generate
      if (A_WINS) begin : g_a_last
         always_ff @(posedge clk) begin
            if (b_en && b_we) mem[b_addr] <= b_wd;
            if (a_en && a_we) mem[a_addr] <= a_wd;
         end
      end else begin : g_b_last
         always_ff @(posedge clk) begin
            if (a_en && a_we) mem[a_addr] <= a_wd;
            if (b_en && b_we) mem[b_addr] <= b_wd;
         end
      end
   endgenerate

   // one-cycle registered reads, old data on a same-cycle write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_rd <= '0;
         b_rd <= '0;
      end else begin
         if (a_en) a_rd <= mem[a_addr];
         if (b_en) b_rd <= mem[b_addr];
      end
   end

endmodule

// File: rtl/opmem_owner.sv
module opmem_owner import opmem_pkg::*; #(
   parameter int NBANK = 3,
   parameter int AW    = 4,
   localparam int BW   = idx_w(NBANK)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             busy_req,
   input  logic             host_en,
   input  logic             host_we,
   input  logic [BW+AW-1:0] host_addr,
   input  logic             cp_active,
   input  logic             cp_accept,
   output logic             busy,
   output logic             host_go,
   output logic [BW-1:0]    host_bank,
   output logic [BW-1:0]    host_bank_q,
   output logic             host_rvalid,
   output logic             host_err
);

   logic bank_ok;

   assign host_bank = host_addr[AW +: BW];
   assign bank_ok   = int'(host_bank) < NBANK;
   assign host_go   = host_en && !busy && bank_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy        <= 1'b0;
         host_err    <= 1'b0;
         host_rvalid <= 1'b0;
         host_bank_q <= '0;
      end else begin
         // ownership moves only between host transactions, never mid-copy (R6)
         if (!host_go) busy <= (cp_active || cp_accept) ? 1'b1 : busy_req;
         // dropped host requests leave a sticky mark (R5)
         if (host_en && (busy || !bank_ok)) host_err <= 1'b1;
         host_rvalid <= host_go && !host_we;
         if (host_go) host_bank_q <= host_bank;
      end
   end

endmodule

// File: rtl/opmem_copy_eng.sv
module opmem_copy_eng import opmem_pkg::*; #(
   parameter int NBANK = 3,
   parameter int DW    = 16,
   parameter int AW    = 4,
   localparam int BW   = idx_w(NBANK)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               arm,
   input  logic               start,
   input  logic [BW-1:0]      src,
   input  logic [BW-1:0]      dst,
   input  logic [AW-1:0]      off,
   input  logic [AW:0]        cnt,
   input  logic [NBANK*DW-1:0] pb_rdata,
   output logic               accept,
   output logic               active,
   output logic               done,
   output logic [BW-1:0]      src_q,
   output logic [BW-1:0]      dst_q,
   output logic               rd_en,
   output logic [AW-1:0]      rd_addr,
   output logic               wr_en,
   output logic [AW-1:0]      wr_addr,
   output logic [DW-1:0]      wr_data
);

   logic [AW:0] left_q;

   // malformed or untimely commands fall through (R11)
   assign accept = start && arm && !active && (cnt != '0) && (src != dst)
                   && (int'(src) < NBANK) && (int'(dst) < NBANK);
   assign rd_en   = active && (left_q != '0);
   assign wr_data = pb_rdata[int'(src_q)*DW +: DW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         done    <= 1'b0;
         left_q  <= '0;
         rd_addr <= '0;
         wr_addr <= '0;
         wr_en   <= 1'b0;
         src_q   <= '0;
         dst_q   <= '0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            active  <= 1'b1;
            left_q  <= cnt;
            rd_addr <= off;
            src_q   <= src;
            dst_q   <= dst;
            wr_en   <= 1'b0;
         end else if (active) begin
            // read word k, write it one cycle later (R8)
            wr_en <= rd_en;
            if (rd_en) begin
               rd_addr <= rd_addr + 1'b1;
               left_q  <= left_q - 1'b1;
               wr_addr <= rd_addr;
            end
            // last write retires: release and pulse (R9)
            if (wr_en && !rd_en) begin
               active <= 1'b0;
               done   <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/opmem_banked.sv
module opmem_banked import opmem_pkg::*; #(
   parameter int NBANK  = 3,
   parameter int DW     = 16,
   parameter int AW     = 4,
   parameter bit A_WINS = 1'b1,
   localparam int BW    = idx_w(NBANK)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NBANK-1:0]    mul_en,
   input  logic [NBANK-1:0]    mul_we,
   input  logic [NBANK*AW-1:0] mul_addr,
   input  logic [NBANK*DW-1:0] mul_wdata,
   output logic [NBANK*DW-1:0] mul_rdata,
   input  logic                busy_req,
   output logic                busy,
   input  logic                host_en,
   input  logic                host_we,
   input  logic [BW+AW-1:0]    host_addr,
   input  logic [DW-1:0]       host_wdata,
   output logic [DW-1:0]       host_rdata,
   output logic                host_rvalid,
   output logic                host_err,
   input  logic [NBANK-1:0]    alu_en,
   input  logic [NBANK-1:0]    alu_we,
   input  logic [NBANK*AW-1:0] alu_addr,
   input  logic [NBANK*DW-1:0] alu_wdata,
   output logic [NBANK*DW-1:0] alu_rdata,
   input  logic                copy_start,
   input  logic [BW-1:0]       copy_src,
   input  logic [BW-1:0]       copy_dst,
   input  logic [AW-1:0]       copy_off,
   input  logic [AW:0]         copy_cnt,
   output logic                copy_busy,
   output logic                copy_done
);

   initial begin : elab_chk
      assert (NBANK >= 2 && NBANK <= 16) else $fatal(1, "NBANK out of range");
      assert (DW >= 1 && DW <= 1024) else $fatal(1, "DW out of range");
      assert (AW >= 1 && AW <= 12) else $fatal(1, "AW out of range");
   end

   logic          host_go;
   logic [BW-1:0] host_bank, host_bank_q;
   logic          cp_accept, cp_active, cp_rd_en, cp_wr_en;
   logic [BW-1:0] cp_src, cp_dst;
   logic [AW-1:0] cp_rd_addr, cp_wr_addr;
   logic [DW-1:0] cp_wr_data;

   opmem_owner #(.NBANK(NBANK), .AW(AW)) u_owner (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy_req   (busy_req),
      .host_en    (host_en),
      .host_we    (host_we),
      .host_addr  (host_addr),
      .cp_active  (cp_active),
      .cp_accept  (cp_accept),
      .busy       (busy),
      .host_go    (host_go),
      .host_bank  (host_bank),
      .host_bank_q(host_bank_q),
      .host_rvalid(host_rvalid),
      .host_err   (host_err)
   );

   opmem_copy_eng #(.NBANK(NBANK), .DW(DW), .AW(AW)) u_copy (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (busy),
      .start   (copy_start),
      .src     (copy_src),
      .dst     (copy_dst),
      .off     (copy_off),
      .cnt     (copy_cnt),
      .pb_rdata(alu_rdata),
      .accept  (cp_accept),
      .active  (cp_active),
      .done    (copy_done),
      .src_q   (cp_src),
      .dst_q   (cp_dst),
      .rd_en   (cp_rd_en),
      .rd_addr (cp_rd_addr),
      .wr_en   (cp_wr_en),
      .wr_addr (cp_wr_addr),
      .wr_data (cp_wr_data)
   );

   assign copy_busy  = cp_active;
   assign host_rdata = alu_rdata[int'(host_bank_q)*DW +: DW];

   generate
      for (genvar i = 0; i < NBANK; i++) begin : g_bank
         pb_owner_e     own;
         logic          pb_en, pb_we;
         logic [AW-1:0] pb_addr;
         logic [DW-1:0] pb_wd;

         // second-port owner: host when idle, else copy engine on its two banks, else arithmetic unit
         always_comb begin
            if (!busy)                                 own = PB_HOST;
            else if (cp_active && int'(cp_src) == i)   own = PB_CPRD;
            else if (cp_active && int'(cp_dst) == i)   own = PB_CPWR;
            else                                       own = PB_ALU;
         end

         always_comb begin
            pb_en   = 1'b0;
            pb_we   = 1'b0;
            pb_addr = '0;
            pb_wd   = '0;
            unique case (own)
               PB_HOST: begin
                  pb_en   = host_go && (int'(host_bank) == i);
                  pb_we   = host_we;
                  pb_addr = host_addr[AW-1:0];
                  pb_wd   = host_wdata;
               end
               PB_CPRD: begin
                  pb_en   = cp_rd_en;
                  pb_addr = cp_rd_addr;
               end
               PB_CPWR: begin
                  pb_en   = cp_wr_en;
                  pb_we   = 1'b1;
                  pb_addr = cp_wr_addr;
                  pb_wd   = cp_wr_data;
               end
               default: begin
                  pb_en   = alu_en[i];
                  pb_we   = alu_we[i];
                  pb_addr = alu_addr[i*AW +: AW];
                  pb_wd   = alu_wdata[i*DW +: DW];
               end
            endcase
         end

         // port A: private, unregistered path to multiplier i (R1, R2)
         opmem_bank #(.DW(DW), .AW(AW), .A_WINS(A_WINS)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .a_en  (mul_en[i]),
            .a_we  (mul_we[i]),
            .a_addr(mul_addr[i*AW +: AW]),
            .a_wd  (mul_wdata[i*DW +: DW]),
            .a_rd  (mul_rdata[i*DW +: DW]),
            .b_en  (pb_en),
            .b_we  (pb_we),
            .b_addr(pb_addr),
            .b_wd  (pb_wd),
            .b_rd  (alu_rdata[i*DW +: DW])
         );
      end
   endgenerate

endmodule

// File: rtl/opmem_banked_chk.sv
module opmem_banked_chk import opmem_pkg::*; #(
   parameter int NBANK = 3,
   parameter int AW    = 4,
   localparam int BW   = idx_w(NBANK)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             host_en,
   input logic             host_we,
   input logic [BW+AW-1:0] host_addr,
   input logic             host_rvalid,
   input logic             host_err,
   input logic             copy_busy,
   input logic             copy_done
);

   // R5: the error flag never clears outside reset
   p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      host_err |=> host_err);

   // R5: a request made while busy returns nothing
   p_drop_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (host_en && busy) |=> !host_rvalid);

   // R4: read data appears only after an accepted host read
   p_rvalid_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
      host_rvalid |-> $past(host_en && !host_we && !busy));

   // R6: an accepted host access pins ownership on the host side
   p_hold_host_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (host_en && !busy && (int'(host_addr[AW +: BW]) < NBANK)) |=> !busy);

   // R6: ownership cannot leave the arithmetic side mid-copy
   p_copy_holds_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      copy_busy |=> busy);

   // R8: copies only run while the arithmetic side owns the ports
   p_copy_needs_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      copy_busy |-> busy);

   // R9: completion coincides with the fall of copy_busy
   p_done_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      copy_done == $fell(copy_busy));

   // R9: completion is a single-cycle pulse
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      copy_done |=> !copy_done);

endmodule

bind opmem_banked opmem_banked_chk #(.NBANK(NBANK), .AW(AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .host_en    (host_en),
   .host_we    (host_we),
   .host_addr  (host_addr),
   .host_rvalid(host_rvalid),
   .host_err   (host_err),
   .copy_busy  (copy_busy),
   .copy_done  (copy_done)
);

// File: tb/opmem_banked_bench.sv
`timescale 1ns/1ps
module opmem_banked_bench;
   localparam int NB = 3;
   localparam int DW = 16;
   localparam int AW = 4;
   localparam int BW = 2;
   localparam int DEPTH = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [NB-1:0]    mul_en = '0, mul_we = '0;
   logic [NB*AW-1:0] mul_addr = '0;
   logic [NB*DW-1:0] mul_wdata = '0, mul_rdata;
   logic             busy_req = 1'b0, busy;
   logic             host_en = 1'b0, host_we = 1'b0;
   logic [BW+AW-1:0] host_addr = '0;
   logic [DW-1:0]    host_wdata = '0, host_rdata;
   logic             host_rvalid, host_err;
   logic [NB-1:0]    alu_en = '0, alu_we = '0;
   logic [NB*AW-1:0] alu_addr = '0;
   logic [NB*DW-1:0] alu_wdata = '0, alu_rdata;
   logic             copy_start = 1'b0;
   logic [BW-1:0]    copy_src = '0, copy_dst = '0;
   logic [AW-1:0]    copy_off = '0;
   logic [AW:0]      copy_cnt = '0;
   logic             copy_busy, copy_done;

   opmem_banked #(.NBANK(NB), .DW(DW), .AW(AW)) u_opmem_banked (
      .clk(clk), .rst_n(rst_n),
      .mul_en(mul_en), .mul_we(mul_we), .mul_addr(mul_addr), .mul_wdata(mul_wdata), .mul_rdata(mul_rdata),
      .busy_req(busy_req), .busy(busy),
      .host_en(host_en), .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .host_rvalid(host_rvalid), .host_err(host_err),
      .alu_en(alu_en), .alu_we(alu_we), .alu_addr(alu_addr), .alu_wdata(alu_wdata), .alu_rdata(alu_rdata),
      .copy_start(copy_start), .copy_src(copy_src), .copy_dst(copy_dst), .copy_off(copy_off),
      .copy_cnt(copy_cnt), .copy_busy(copy_busy), .copy_done(copy_done)
   );

   int nchk = 0;
   int nfail = 0;
   logic [DW-1:0] model [NB][DEPTH];

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int b, input int w);
      return DW'(b * 4099 + w * 37 + 11);
   endfunction

   task automatic host_wr(input int b, input int w, input logic [DW-1:0] d);
      host_en = 1'b1; host_we = 1'b1;
      host_addr = {BW'(b), AW'(w)}; host_wdata = d;
      tick();
      host_en = 1'b0; host_we = 1'b0;
   endtask

   task automatic host_rd(input int b, input int w, output logic [DW-1:0] d, output logic v);
      host_en = 1'b1; host_we = 1'b0;
      host_addr = {BW'(b), AW'(w)};
      tick();
      d = host_rdata; v = host_rvalid;
      host_en = 1'b0;
   endtask

   task automatic host_sweep(input string tag);
      logic [DW-1:0] d;
      logic v;
      for (int b = 0; b < NB; b++)
         for (int w = 0; w < DEPTH; w++) begin
            host_rd(b, w, d, v);
            chk({tag, " rvalid"}, 32'(v), 32'd1);
            chk(tag, 32'(d), 32'(model[b][w]));
         end
   endtask

   task automatic mul_sweep(input string tag);
      for (int w = 0; w < DEPTH; w++) begin
         mul_en = '1; mul_we = '0;
         for (int b = 0; b < NB; b++) mul_addr[b*AW +: AW] = AW'(w);
         tick();
         for (int b = 0; b < NB; b++) chk(tag, 32'(mul_rdata[b*DW +: DW]), 32'(model[b][w]));
         mul_en = '0;
      end
   endtask

   task automatic alu_sweep(input string tag);
      for (int w = 0; w < DEPTH; w++) begin
         alu_en = '1; alu_we = '0;
         for (int b = 0; b < NB; b++) alu_addr[b*AW +: AW] = AW'(w);
         tick();
         for (int b = 0; b < NB; b++) chk(tag, 32'(alu_rdata[b*DW +: DW]), 32'(model[b][w]));
         alu_en = '0;
      end
   endtask

   task automatic do_copy(input int src, input int dst, input int off, input int cnt,
                          input bit side, input bit drop);
      int n;
      copy_src = BW'(src); copy_dst = BW'(dst); copy_off = AW'(off); copy_cnt = (AW+1)'(cnt);
      copy_start = 1'b1;
      tick();
      copy_start = 1'b0;
      chk("R9 copy_busy after accept", 32'(copy_busy), 32'd1);
      if (drop) busy_req = 1'b0;
      if (side) begin
         // R10: bank 2 free for the arithmetic unit, destination bank 1 request ignored
         alu_en = 3'b110; alu_we = 3'b110;
         alu_addr[2*AW +: AW] = 4'd9;  alu_wdata[2*DW +: DW] = 16'h9999;
         alu_addr[1*AW +: AW] = 4'd15; alu_wdata[1*DW +: DW] = 16'hDEAD;
      end
      n = 0;
      while (!copy_done && n < 40) begin
         tick();
         n++;
         if (!copy_done) chk("R9 copy_busy held", 32'(copy_busy), 32'd1);
      end
      alu_en = '0; alu_we = '0;
      chk("R9 cycles to done", 32'(n), 32'(cnt + 1));
      chk("R9 copy_busy low at done", 32'(copy_busy), 32'd0);
      if (side) model[2][9] = 16'h9999;
      for (int k = 0; k < cnt; k++) model[dst][(off + k) % DEPTH] = model[src][(off + k) % DEPTH];
      if (drop) begin
         chk("R6 busy held through copy end", 32'(busy), 32'd1);
         tick();
         chk("R6 busy falls after copy", 32'(busy), 32'd0);
         chk("R9 done single pulse", 32'(copy_done), 32'd0);
         busy_req = 1'b1;
         tick();
         chk("R6 busy returns", 32'(busy), 32'd1);
      end else begin
         tick();
         chk("R9 done single pulse", 32'(copy_done), 32'd0);
      end
   endtask

   task automatic bad_copy(input string tag, input int src, input int dst, input int cnt);
      copy_src = BW'(src); copy_dst = BW'(dst); copy_off = 4'd3; copy_cnt = (AW+1)'(cnt);
      copy_start = 1'b1;
      tick();
      copy_start = 1'b0;
      chk({tag, " copy_busy"}, 32'(copy_busy), 32'd0);
      tick();
      chk({tag, " copy_done"}, 32'(copy_done), 32'd0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin : main
      logic [DW-1:0] d;
      logic v;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      chk("reset busy", 32'(busy), 32'd0);
      chk("reset host_err", 32'(host_err), 32'd0);
      chk("reset host_rvalid", 32'(host_rvalid), 32'd0);
      chk("reset copy_busy", 32'(copy_busy), 32'd0);
      chk("reset copy_done", 32'(copy_done), 32'd0);

      // R4: fill every bank through the host address split, read it back
      for (int b = 0; b < NB; b++)
         for (int w = 0; w < DEPTH; w++) begin
            host_wr(b, w, pat(b, w));
            model[b][w] = pat(b, w);
         end
      tick();
      chk("R4 no stray rvalid after write", 32'(host_rvalid), 32'd0);
      host_sweep("R4 host read");

      // R1: each multiplier sees its own bank
      mul_sweep("R1 mul read");

      // R2: a multiplier write stays in its bank
      for (int i = 0; i < NB; i++) begin
         mul_en = '0; mul_we = '0;
         mul_en[i] = 1'b1; mul_we[i] = 1'b1;
         mul_addr[i*AW +: AW] = 4'd7;
         mul_wdata[i*DW +: DW] = DW'(16'hA000 + i);
         tick();
         mul_en = '0; mul_we = '0;
         model[i][7] = DW'(16'hA000 + i);
         for (int b = 0; b < NB; b++) begin
            host_rd(b, 7, d, v);
            chk("R2 private write", 32'(d), 32'(model[b][7]));
         end
      end

      // R5: out-of-range bank index is dropped
      host_rd(3, 0, d, v);
      chk("R5 bad bank rvalid", 32'(v), 32'd0);
      chk("R5 bad bank err", 32'(host_err), 32'd1);

      // R6: a host access at the switching edge holds ownership
      busy_req = 1'b1;
      host_rd(0, 1, d, v);
      chk("R6 busy held by host access", 32'(busy), 32'd0);
      chk("R4 read at switch edge", 32'(d), 32'(model[0][1]));
      tick();
      chk("R6 busy follows request", 32'(busy), 32'd1);

      // R5: host blocked while busy
      host_wr(0, 0, 16'hFFFF);
      host_rd(1, 2, d, v);
      chk("R5 busy drop rvalid", 32'(v), 32'd0);
      chk("R5 err sticky", 32'(host_err), 32'd1);

      // R7: parallel arithmetic-unit writes and reads on every bank
      alu_en = '1; alu_we = '1;
      for (int b = 0; b < NB; b++) begin
         alu_addr[b*AW +: AW] = AW'(10 + b);
         alu_wdata[b*DW +: DW] = DW'(16'hB000 + b);
         model[b][10 + b] = DW'(16'hB000 + b);
      end
      tick();
      alu_en = '0; alu_we = '0;
      alu_sweep("R7 alu read");
      mul_sweep("R7 mul sees alu writes");

      // R3: same-address collision goes to the multiplier port
      mul_en = 3'b011; mul_we = 3'b011;
      alu_en = 3'b011; alu_we = 3'b011;
      mul_addr[0 +: AW] = 4'd5;      mul_wdata[0 +: DW] = 16'h5A5A;
      alu_addr[0 +: AW] = 4'd5;      alu_wdata[0 +: DW] = 16'hC3C3;
      mul_addr[AW +: AW] = 4'd3;     mul_wdata[DW +: DW] = 16'h1111;
      alu_addr[AW +: AW] = 4'd4;     alu_wdata[DW +: DW] = 16'h2222;
      tick();
      mul_en = '0; mul_we = '0; alu_en = '0; alu_we = '0;
      model[0][5] = 16'h5A5A; model[1][3] = 16'h1111; model[1][4] = 16'h2222;
      alu_sweep("R3 dual write");

      // R8 R9 R10: mid-bank copy with side traffic
      do_copy(0, 1, 2, 5, 1'b1, 1'b0);
      alu_sweep("R10 R8 after copy 0->1");
      // R8: wrapping copy, with busy request dropped meanwhile (R6)
      do_copy(2, 0, 14, 4, 1'b0, 1'b1);
      alu_sweep("R8 after wrap copy 2->0");
      // R8: whole bank
      do_copy(1, 2, 0, 16, 1'b0, 1'b0);
      alu_sweep("R8 after full copy 1->2");

      // R11: malformed commands
      bad_copy("R11 src equals dst", 1, 1, 3);
      bad_copy("R11 zero count", 0, 1, 0);
      bad_copy("R11 bank out of range", 0, 3, 2);
      busy_req = 1'b0;
      tick();
      chk("R6 busy drops", 32'(busy), 32'd0);
      bad_copy("R11 not busy", 0, 2, 2);

      // R4 R11: final image through the host path
      host_sweep("R4 R11 final image");

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule